// File: doc/BRIEF.md
# GPIO Controller with Interrupt Detection

This block is a bank of general-purpose pins behind a small memory-mapped register bus. Software sets the pin direction and output levels, reads the pad levels, and arms each pin to raise an interrupt on a level or on an edge of either polarity. By default the bank has 32 pins. Every register has one bit per pin, and bit n belongs to pin n.

Pad inputs pass through a two-stage synchroniser. The synchronised values feed both the input register and the trigger logic. The trigger for each pin is set by two type bits. The kind bit selects level or edge. The polarity bit selects high/rising or low/falling. Each pin also has an enable bit. Pending events collect in a status register. One interrupt output is high whenever any status bit is set. Reading the status register clears the edge-triggered bits that the read returns. A level-triggered bit follows its condition.

The bus is a single-cycle strobe with a word index. Read data is registered and appears on the cycle after the strobe. A pin change reaches the status register on the third clock edge after it is seen on the pad.

Top module: `gpio_ctrl`

## Requirements
- R1: After a synchronous active-low reset, every register is zero. `pin_oe`, `pin_out`, `irq` and `bus_rdata` are all zero.
- R2: Word index 0 (byte offset 0x00) holds the direction bits. A 1 makes the pin an output. `pin_oe` follows this register from the edge that writes it, and the register reads back as written.
- R3: Word index 2 (offset 0x08) holds the output levels. `pin_out` follows it from the edge that writes it, and it reads back as written.
- R4: Word index 1 (offset 0x04) returns the pad levels after a two-flop synchroniser. A read strobed on the edge right after a pad change returns the old value. A read made three cycles later returns the new value.
- R5: A read strobe at a clock edge loads `bus_rdata` at that edge. `bus_rdata` holds the value until the next read.
- R6: When the kind bit (index 5, offset 0x14) is 0, the pin is level triggered. Its polarity bit (index 4, offset 0x10) selects high when 0 and low when 1. The status bit is set while the condition holds and clears once the condition ends.
- R7: When the kind bit is 1, the pin is edge triggered. Polarity 0 means rising and polarity 1 means falling. An edge in the other direction sets nothing. An edge bit stays set until a status read clears it. There is no double-edge mode.
- R8: A pin whose enable bit (index 3, offset 0x0C) is 0 never sets its status bit.
- R9: Reading the status register (index 6, offset 0x18) returns the pending bits and clears the edge-triggered bits it returned. Level-triggered bits are not cleared by the read.
- R10: A new edge detected in the same cycle as a status read that clears that pin's bit leaves the bit set.
- R11: `irq` is high exactly when at least one status bit is set.
- R12: Writes to the input and status registers change no register and no pending bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 3 | Register word index (byte offset divided by 4) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | 32 | Pad input levels, asynchronous |
| pin_out | output | 32 | Pad output levels |
| pin_oe | output | 32 | Pad output enables (1 = drive) |
| irq | output | 1 | Combined interrupt |

## Verification
A status read that clears an edge bit can fall in the same clock cycle as a fresh edge detected on that same pin. The bench sets up this collision by raising a rising-edge pin two cycles before the strobe of a status read. That places the edge's detection cycle exactly on the read's clock edge. It then judges the outcome with three reads. The colliding read returns the earlier event. The next read must still show the bit set, because the new edge survived the clear. A third read must show it gone.

// File: rtl/gpio_ctrl_pkg.sv
// Shared constants for the GPIO controller: register word indices.
// Assumes the bus presents a word index, not a byte address.
package gpio_ctrl_pkg;
    localparam int unsigned IDX_DIR  = 0;
    localparam int unsigned IDX_IN   = 1;
    localparam int unsigned IDX_OUT  = 2;
    localparam int unsigned IDX_EN   = 3;
    localparam int unsigned IDX_POL  = 4;
    localparam int unsigned IDX_KIND = 5;
    localparam int unsigned IDX_STAT = 6;
endpackage

// File: rtl/gpio_ctrl_sync.sv
// Two-flop synchroniser for the pad inputs, plus one extra history stage
// used by the edge detector. Assumes pads may change at any time.
module gpio_ctrl_sync #(
    parameter int unsigned PINS = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PINS-1:0] pad_i,
    output logic [PINS-1:0] now_o,
    output logic [PINS-1:0] prev_o
);
    logic [PINS-1:0] meta_q;
    logic [PINS-1:0] now_q;
    logic [PINS-1:0] prev_q;

    // Shift pad levels through metastability, synchronised and history stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            now_q  <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= pad_i;
            now_q  <= meta_q;
            prev_q <= now_q;
        end
    end

    assign now_o  = now_q;
    assign prev_o = prev_q;
endmodule

// File: rtl/gpio_ctrl_detect.sv
// Per-pin trigger evaluation. Combinational; splits hits into edge and level.
// Assumes now/prev are consecutive synchronised samples.
module gpio_ctrl_detect #(
    parameter int unsigned PINS = 32
) (
    input  logic [PINS-1:0] now_i,
    input  logic [PINS-1:0] prev_i,
    input  logic [PINS-1:0] en_i,
    input  logic [PINS-1:0] pol_i,
    input  logic [PINS-1:0] kind_i,
    output logic [PINS-1:0] edge_hit_o,
    output logic [PINS-1:0] level_hit_o
);
    for (genvar p = 0; p < PINS; p++) begin : g_pin
        logic rise;
        logic fall;
        logic lvl;
        // Classify the pin's transition and level against its polarity.
        always_comb begin
            rise = now_i[p] & ~prev_i[p];
            fall = ~now_i[p] & prev_i[p];
            lvl  = pol_i[p] ? ~now_i[p] : now_i[p];
            edge_hit_o[p]  = en_i[p] & kind_i[p] & (pol_i[p] ? fall : rise);
            level_hit_o[p] = en_i[p] & ~kind_i[p] & lvl;
        end
    end
endmodule

// File: rtl/gpio_ctrl_status.sv
// Pending-interrupt status: sticky edge bits cleared by a status read,
// level bits that follow their condition. A new edge wins over a clear.
module gpio_ctrl_status #(
    parameter int unsigned PINS = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PINS-1:0] kind_i,
    input  logic [PINS-1:0] en_i,
    input  logic [PINS-1:0] edge_hit_i,
    input  logic [PINS-1:0] level_hit_i,
    input  logic            rd_clr_i,
    output logic [PINS-1:0] stat_o
);
    logic [PINS-1:0] stat_q;
    logic [PINS-1:0] clr_mask;
    logic [PINS-1:0] stat_d;

    // Compute next status: edge bits sticky minus cleared, plus new hits.
    always_comb begin
        clr_mask = rd_clr_i ? stat_q : '0;
        stat_d   = (kind_i & ((stat_q & ~clr_mask) | edge_hit_i))
                 | (~kind_i & level_hit_i);
    end

    // Register the status word.
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= stat_d;
    end

    assign stat_o = stat_q;

    // R7
    edge_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_clr_i |=> (($past(stat_q) & $past(kind_i) & ~stat_q) == '0));

    // R8
    no_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((stat_q & ~$past(kind_i) & ~$past(en_i)) == '0));
endmodule

// File: rtl/gpio_ctrl_regs.sv
// Register file and bus decode. Writable: direction, output, enable,
// polarity, kind. Input and status are read-only. Read data registered.
module gpio_ctrl_regs #(
    parameter int unsigned PINS   = 32,
    parameter int unsigned ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [PINS-1:0]   bus_wdata,
    output logic [PINS-1:0]   bus_rdata,
    input  logic [PINS-1:0]   in_i,
    input  logic [PINS-1:0]   stat_i,
    output logic [PINS-1:0]   dir_o,
    output logic [PINS-1:0]   out_o,
    output logic [PINS-1:0]   en_o,
    output logic [PINS-1:0]   pol_o,
    output logic [PINS-1:0]   kind_o,
    output logic              stat_rd_o
);
    import gpio_ctrl_pkg::*;

    logic [PINS-1:0] dir_q, out_q, en_q, pol_q, kind_q, rdata_q;
    logic            wr_go, rd_go;
    logic [PINS-1:0] rd_mux;

    assign wr_go = bus_sel & bus_wr;
    assign rd_go = bus_sel & ~bus_wr;

    // Select the register addressed by a read.
    always_comb begin
        case (bus_addr)
            ADDR_W'(IDX_DIR):  rd_mux = dir_q;
            ADDR_W'(IDX_IN):   rd_mux = in_i;
            ADDR_W'(IDX_OUT):  rd_mux = out_q;
            ADDR_W'(IDX_EN):   rd_mux = en_q;
            ADDR_W'(IDX_POL):  rd_mux = pol_q;
            ADDR_W'(IDX_KIND): rd_mux = kind_q;
            ADDR_W'(IDX_STAT): rd_mux = stat_i;
            default:           rd_mux = '0;
        endcase
    end

    // Update writable registers on a write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q  <= '0;
            out_q  <= '0;
            en_q   <= '0;
            pol_q  <= '0;
            kind_q <= '0;
        end else if (wr_go) begin
            if (bus_addr == ADDR_W'(IDX_DIR))  dir_q  <= bus_wdata;
            if (bus_addr == ADDR_W'(IDX_OUT))  out_q  <= bus_wdata;
            if (bus_addr == ADDR_W'(IDX_EN))   en_q   <= bus_wdata;
            if (bus_addr == ADDR_W'(IDX_POL))  pol_q  <= bus_wdata;
            if (bus_addr == ADDR_W'(IDX_KIND)) kind_q <= bus_wdata;
        end
    end

    // Capture read data on a read strobe and hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)     rdata_q <= '0;
        else if (rd_go) rdata_q <= rd_mux;
    end

    assign stat_rd_o = rd_go & (bus_addr == ADDR_W'(IDX_STAT));
    assign bus_rdata = rdata_q;
    assign dir_o     = dir_q;
    assign out_o     = out_q;
    assign en_o      = en_q;
    assign pol_o     = pol_q;
    assign kind_o    = kind_q;

    // R5
    rdata_stat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rd_o |=> (bus_rdata == $past(stat_i)));

    // R12
    ro_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_go && (bus_addr == ADDR_W'(IDX_IN) || bus_addr == ADDR_W'(IDX_STAT)))
        |=> ($stable(dir_q) && $stable(out_q) && $stable(en_q)
             && $stable(pol_q) && $stable(kind_q)));
endmodule

// File: rtl/gpio_ctrl.sv
// GPIO controller top: synchroniser, trigger detection, status capture,
// register file and combined interrupt. Assumes one access per strobe cycle.
module gpio_ctrl #(
    parameter int unsigned PINS   = 32,
    parameter int unsigned ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [PINS-1:0]   bus_wdata,
    output logic [PINS-1:0]   bus_rdata,
    input  logic [PINS-1:0]   pin_in,
    output logic [PINS-1:0]   pin_out,
    output logic [PINS-1:0]   pin_oe,
    output logic              irq
);
    logic [PINS-1:0] now_s, prev_s;
    logic [PINS-1:0] en_r, pol_r, kind_r;
    logic [PINS-1:0] edge_hit, level_hit, status;
    logic            stat_rd;

    gpio_ctrl_sync #(.PINS(PINS)) u_sync (
        .clk(clk), .rst_n(rst_n), .pad_i(pin_in),
        .now_o(now_s), .prev_o(prev_s)
    );

    gpio_ctrl_regs #(.PINS(PINS), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .in_i(now_s), .stat_i(status),
        .dir_o(pin_oe), .out_o(pin_out), .en_o(en_r),
        .pol_o(pol_r), .kind_o(kind_r), .stat_rd_o(stat_rd)
    );

    gpio_ctrl_detect #(.PINS(PINS)) u_detect (
        .now_i(now_s), .prev_i(prev_s), .en_i(en_r),
        .pol_i(pol_r), .kind_i(kind_r),
        .edge_hit_o(edge_hit), .level_hit_o(level_hit)
    );

    gpio_ctrl_status #(.PINS(PINS)) u_status (
        .clk(clk), .rst_n(rst_n), .kind_i(kind_r), .en_i(en_r),
        .edge_hit_i(edge_hit), .level_hit_i(level_hit),
        .rd_clr_i(stat_rd), .stat_o(status)
    );

    assign irq = |status;

    // R10
    collide_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && (edge_hit != '0))
        |=> ((status & $past(edge_hit)) == $past(edge_hit)));
endmodule

// File: tb/tb_gpio_ctrl.sv
module tb_gpio_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_out;
    logic [31:0] pin_oe;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    localparam logic [2:0] A_DIR = 3'd0, A_IN = 3'd1, A_OUT = 3'd2, A_EN = 3'd3,
                           A_POL = 3'd4, A_KIND = 3'd5, A_STAT = 3'd6;

    // Fields: pin[10:6] kind[5] pol[4] en[3] start[2] end[1] expected[0]
    localparam int NV = 10;
    localparam logic [10:0] VEC [NV] = '{
        {5'd2,  1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1},
        {5'd5,  1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0},
        {5'd7,  1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1},
        {5'd9,  1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1},
        {5'd11, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0},
        {5'd13, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1},
        {5'd31, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0},
        {5'd0,  1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},
        {5'd20, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0},
        {5'd16, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1}
    };

    gpio_ctrl dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    always #5 clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
        d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [31:0] m;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 pin_oe", pin_oe, 32'h0);
        check("R1 pin_out", pin_out, 32'h0);
        check("R1 irq", {31'h0, irq}, 32'h0);
        check("R1 rdata", bus_rdata, 32'h0);
        for (int a = 0; a < 7; a++) begin
            bus_read(3'(a), d);
            check("R1 register", d, 32'h0);
        end

        // R2, R3 direction and output
        bus_write(A_DIR, 32'hA5A5_0F0F);
        check("R2 pin_oe", pin_oe, 32'hA5A5_0F0F);
        bus_write(A_OUT, 32'h1234_8001);
        check("R3 pin_out", pin_out, 32'h1234_8001);
        bus_read(A_DIR, d);
        check("R2 readback", d, 32'hA5A5_0F0F);
        bus_read(A_OUT, d);
        check("R3 readback", d, 32'h1234_8001);

        // R4, R5 synchronised input
        @(negedge clk);
        pin_in = 32'hDEAD_BEEF;
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = A_IN;
        @(negedge clk);
        bus_sel = 1'b0;
        check("R4 input latency", bus_rdata, 32'h0);
        idle(2);
        check("R5 rdata held", bus_rdata, 32'h0);
        bus_read(A_IN, d);
        check("R4 input value", d, 32'hDEAD_BEEF);
        pin_in = '0;
        idle(4);

        // R6 R7 R8 R11 vector table
        for (int i = 0; i < NV; i++) begin
            logic [10:0] v;
            v = VEC[i];
            m = 32'h1 << v[10:6];
            bus_write(A_EN, 32'h0);
            pin_in = v[2] ? m : 32'h0;
            bus_write(A_KIND, v[5] ? m : 32'h0);
            bus_write(A_POL, v[4] ? m : 32'h0);
            idle(4);
            bus_write(A_EN, v[3] ? m : 32'h0);
            idle(4);
            bus_read(A_STAT, d);
            pin_in = v[1] ? m : 32'h0;
            idle(4);
            check("R6/R7/R8 irq", {31'h0, irq}, {31'h0, v[0]});
            bus_read(A_STAT, d);
            check("R6/R7/R8 status", d, v[0] ? m : 32'h0);
        end

        // R9 level bit survives repeated reads (pin 16 level high still held)
        bus_read(A_STAT, d);
        check("R9 level read 1", d, 32'h0001_0000);
        bus_read(A_STAT, d);
        check("R9 level read 2", d, 32'h0001_0000);

        // R10 clear and new edge in one cycle, pin 3 rising
        bus_write(A_EN, 32'h0);
        pin_in = '0;
        bus_write(A_KIND, 32'h8);
        bus_write(A_POL, 32'h0);
        idle(4);
        bus_write(A_EN, 32'h8);
        idle(4);
        bus_read(A_STAT, d);
        check("R9 start clear", d, 32'h0);
        pin_in[3] = 1'b1;
        idle(4);
        pin_in[3] = 1'b0;
        idle(4);
        check("R11 irq pending", {31'h0, irq}, 32'h1);
        @(negedge clk);
        pin_in[3] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = A_STAT;
        @(negedge clk);
        bus_sel = 1'b0;
        check("R10 colliding read", bus_rdata, 32'h8);
        bus_read(A_STAT, d);
        check("R10 new edge kept", d, 32'h8);
        bus_read(A_STAT, d);
        check("R9 edge cleared", d, 32'h0);
        check("R11 irq idle", {31'h0, irq}, 32'h0);

        // R12 writes to input and status ignored
        pin_in[3] = 1'b0;
        idle(4);
        pin_in[3] = 1'b1;
        idle(4);
        bus_write(A_STAT, 32'h0);
        bus_write(A_IN, 32'hFFFF_FFFF);
        bus_write(A_STAT, 32'hFFFF_FFFF);
        bus_read(A_STAT, d);
        check("R12 status kept", d, 32'h8);
        bus_read(A_IN, d);
        check("R12 input unchanged", d, 32'h8);
        bus_read(A_DIR, d);
        check("R12 dir unchanged", d, 32'hA5A5_0F0F);
        bus_read(A_KIND, d);
        check("R12 kind unchanged", d, 32'h8);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule